// File: doc/BRIEF.md
# Card Window Address Mapper and Strobe Sequencer

This block sits between a host port and one card socket. The host reaches the card through three programmable windows. Each window is a fixed 1 MB aperture. A host access names a window and a 20-bit offset. The block forms a 26-bit card address from the window's 6-bit page number and the untouched offset. It also drives the card address space that the window selects: attribute memory, common memory or I/O.

Each access then runs through a timed command cycle. The cycle has a programmable setup delay, a command strobe of programmable length, an optional extension controlled by the card's wait line, and a programmable recovery gap. The cycle finishes with a one-cycle acknowledge to the host. If the wait line never releases, the access is abandoned and reported as a timeout.

Each window has two 16-bit control words. These are written and read through a small register port. The timing fields of a window are copied at the moment its access starts, so a rewrite has no effect on an access that is already running.

Top module: `card_win_seq`

## Requirements
- R1: After reset, every control word reads 0, and `card_cmd`, `host_ack` and `host_timeout` are low.
- R2: The control words of window w sit at byte offset 4w (word A) and 4w+2 (word B). Address bit 0 is ignored. Word A bit 15 and word B bits 15:5 always read 0. At offsets 12 to 15 a write is ignored and a read returns 0.
- R3: While `card_cmd` is high, `card_addr` equals {word A bits 5:0, host offset bits 19:0}. `card_space` equals word A bits 7:6, where 00 is attribute, 01 is common and 10 is I/O. `card_we` and `card_wdata` carry the host write flag and write data.
- R4: Call the clock edge that accepts a request E0. After E0, `card_cmd` stays low for (word A bits 9:8)+1 cycles. It is then high for (word A bits 14:10)+1 cycles. It is then low for (word B bits 4:3)+1 recovery cycles. The next cycle has `host_ack` high for exactly one cycle.
- R5: When word B bit 0 is set, `card_cmd` stays high for a further (word B bits 2:1)+1 cycles after the strobe length. It then samples `card_wait_n` each cycle and stays high while that line is low. The strobe ends with the first cycle in which the line is seen high. When word B bit 0 is clear, `card_wait_n` has no effect.
- R6: If `card_wait_n` is sampled low in 256 consecutive sampling cycles, the strobe ends. Recovery then runs as usual, and the acknowledge cycle carries `host_timeout` high and `host_rdata` = 16'hFFFF.
- R7: On a normal completion, `host_rdata` during the acknowledge cycle equals the value `card_rdata` had in the last cycle of `card_cmd` high.
- R8: A request for window 3 is acknowledged in the cycle right after the accepting edge. It produces no `card_cmd`, `host_rdata` = 16'hFFFF and no timeout.
- R9: A request is ignored from its accepting edge through the last recovery cycle. A request present during the acknowledge cycle is accepted.
- R10: A control word write in the same cycle as an accepted request for that window does not affect that access. The next access uses the new value.
- R11: `card_addr`, `card_space`, `card_we` and `card_wdata` stay stable for the whole access, even if the host inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_addr | input | 4 | Control word byte offset |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Control word read data at `cfg_addr` |
| host_req | input | 1 | Access request |
| host_win | input | 2 | Window select, 3 is invalid |
| host_ofs | input | 20 | Offset inside the window |
| host_wr | input | 1 | Access is a write |
| host_wdata | input | 16 | Host write data |
| host_ack | output | 1 | One-cycle access completion |
| host_rdata | output | 16 | Read data, valid with `host_ack` |
| host_timeout | output | 1 | Wait timeout, valid with `host_ack` |
| card_addr | output | 26 | Card address |
| card_space | output | 2 | Card address space select |
| card_cmd | output | 1 | Command strobe |
| card_we | output | 1 | Card write direction |
| card_wdata | output | 16 | Card write data |
| card_rdata | input | 16 | Card read data |
| card_wait_n | input | 1 | Card wait, low extends the strobe |

## Verification
Two pairs of events can fall in the same cycle: a control word write and the request that will use that window, and a new request and the acknowledge of the previous access. The bench drives a write and a request on the same edge. It also holds the request high across a whole access, so that a second access starts in the acknowledge cycle. A cycle-accurate model takes its timing snapshot before it applies the write. That model judges the strobe pattern, the address and the acknowledge count of both accesses on every clock.

// File: rtl/card_win_pkg.sv
package card_win_pkg;

  localparam int REG_W = 16;

  // Implemented bits of the two control words of a window.
  localparam logic [REG_W-1:0] CTLA_MASK = 16'h7FFF;
  localparam logic [REG_W-1:0] CTLB_MASK = 16'h001F;

  typedef struct packed {
    logic [4:0] len;     // strobe length, cycles minus one
    logic [1:0] dly;     // setup delay, cycles minus one
    logic [1:0] rec;     // recovery, cycles minus one
    logic [1:0] wdly;    // wait sampling delay, cycles minus one
    logic       honour;  // wait line extends the strobe
  } win_tim_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP,
    SQ_STROBE,
    SQ_WDLY,
    SQ_WCHK,
    SQ_RECOV
  } seq_st_t;

  function automatic win_tim_t unpack_tim(input logic [REG_W-1:0] wa,
                                          input logic [REG_W-1:0] wb);
    win_tim_t t;
    t.len    = wa[14:10];
    t.dly    = wa[9:8];
    t.rec    = wb[4:3];
    t.wdly   = wb[2:1];
    t.honour = wb[0];
    return t;
  endfunction

endpackage

// File: rtl/card_win_regs.sv
module card_win_regs
  import card_win_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int ADDR_W = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [ADDR_W-1:0]          cfg_addr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  output logic [NWIN-1:0][REG_W-1:0] ctl_a,
  output logic [NWIN-1:0][REG_W-1:0] ctl_b
);

  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic              word_b;

  assign widx   = cfg_addr[ADDR_W-1:2];
  assign word_b = cfg_addr[1];

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      logic             hit;
      logic             en_a;
      logic             en_b;
      logic [REG_W-1:0] ra_q;
      logic [REG_W-1:0] rb_q;

      assign hit  = cfg_we && (widx == WIDX_W'(g));
      assign en_a = hit && !word_b;
      assign en_b = hit && word_b;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ra_q <= '0;
        end else if (en_a) begin
          ra_q <= cfg_wdata & CTLA_MASK;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          rb_q <= '0;
        end else if (en_b) begin
          rb_q <= cfg_wdata & CTLB_MASK;
        end
      end

      assign ctl_a[g] = ra_q;
      assign ctl_b[g] = rb_q;
    end
  endgenerate

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NWIN; i++) begin
      if (widx == WIDX_W'(i)) begin
        cfg_rdata = word_b ? ctl_b[i] : ctl_a[i];
      end
    end
  end

endmodule

// File: rtl/card_win_xlate.sv
module card_win_xlate
  import card_win_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int WSEL_W = 2,
  parameter int OFS_W  = 20,
  parameter int PAGE_W = 6
) (
  input  logic [NWIN-1:0][REG_W-1:0] ctl_a,
  input  logic [NWIN-1:0][REG_W-1:0] ctl_b,
  input  logic [WSEL_W-1:0]          host_win,
  input  logic [OFS_W-1:0]           host_ofs,
  output logic                       win_ok,
  output logic [PAGE_W+OFS_W-1:0]    xaddr,
  output logic [1:0]                 xspace,
  output win_tim_t                   xtim
);

  logic [REG_W-1:0] wa;
  logic [REG_W-1:0] wb;

  always_comb begin
    wa     = '0;
    wb     = '0;
    win_ok = 1'b0;
    for (int i = 0; i < NWIN; i++) begin
      if (host_win == WSEL_W'(i)) begin
        wa     = ctl_a[i];
        wb     = ctl_b[i];
        win_ok = 1'b1;
      end
    end
  end

  assign xaddr  = {wa[PAGE_W-1:0], host_ofs};
  assign xspace = wa[7:6];
  assign xtim   = unpack_tim(wa, wb);

endmodule

// File: rtl/card_win_strobe.sv
module card_win_strobe
  import card_win_pkg::*;
#(
  parameter int CA_W   = 26,
  parameter int DATA_W = 16,
  parameter int TO_CYC = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              win_ok,
  input  win_tim_t          tim_in,
  input  logic [CA_W-1:0]   addr_in,
  input  logic [1:0]        space_in,
  input  logic              we_in,
  input  logic [DATA_W-1:0] wdata_in,
  input  logic [DATA_W-1:0] card_rdata,
  input  logic              card_wait_n,
  output logic [CA_W-1:0]   card_addr,
  output logic [1:0]        card_space,
  output logic              card_we,
  output logic [DATA_W-1:0] card_wdata,
  output logic              card_cmd,
  output logic              host_ack,
  output logic              host_timeout,
  output logic [DATA_W-1:0] host_rdata
);

  localparam int CNT_W = $bits(tim_in.len);
  localparam int TC_W  = $clog2(TO_CYC);
  localparam logic [TC_W-1:0] TC_LAST = TC_W'(TO_CYC - 1);

  seq_st_t           st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [TC_W-1:0]   tc_q, tc_n;
  win_tim_t          tim_q;
  logic              top_q, top_n;
  logic              ack_n, to_n;
  logic [DATA_W-1:0] rd_n;
  logic              rd_en;
  logic              ld;

  // Access is accepted only from idle; parameters are snapshotted here.
  assign ld = (st_q == SQ_IDLE) && req && win_ok;

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    tc_n  = tc_q;
    top_n = top_q;
    ack_n = 1'b0;
    to_n  = 1'b0;
    rd_n  = host_rdata;
    rd_en = 1'b0;
    unique case (st_q)
      SQ_IDLE: begin
        if (req) begin
          if (!win_ok) begin
            ack_n = 1'b1;
            rd_n  = '1;
            rd_en = 1'b1;
          end else begin
            st_n  = SQ_SETUP;
            cnt_n = CNT_W'(tim_in.dly);
            top_n = 1'b0;
          end
        end
      end
      SQ_SETUP: begin
        if (cnt_q == '0) begin
          st_n  = SQ_STROBE;
          cnt_n = tim_q.len;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      SQ_STROBE: begin
        if (cnt_q == '0) begin
          if (tim_q.honour) begin
            st_n  = SQ_WDLY;
            cnt_n = CNT_W'(tim_q.wdly);
          end else begin
            st_n  = SQ_RECOV;
            cnt_n = CNT_W'(tim_q.rec);
            rd_n  = card_rdata;
            rd_en = 1'b1;
          end
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      SQ_WDLY: begin
        if (cnt_q == '0) begin
          st_n = SQ_WCHK;
          tc_n = '0;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      SQ_WCHK: begin
        if (card_wait_n) begin
          st_n  = SQ_RECOV;
          cnt_n = CNT_W'(tim_q.rec);
          rd_n  = card_rdata;
          rd_en = 1'b1;
        end else if (tc_q == TC_LAST) begin
          st_n  = SQ_RECOV;
          cnt_n = CNT_W'(tim_q.rec);
          rd_n  = '1;
          rd_en = 1'b1;
          top_n = 1'b1;
        end else begin
          tc_n = tc_q + TC_W'(1);
        end
      end
      SQ_RECOV: begin
        if (cnt_q == '0) begin
          st_n  = SQ_IDLE;
          ack_n = 1'b1;
          to_n  = top_q;
        end else begin
          cnt_n = cnt_q - 1'b1;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= SQ_IDLE;
      cnt_q        <= '0;
      tc_q         <= '0;
      top_q        <= 1'b0;
      host_ack     <= 1'b0;
      host_timeout <= 1'b0;
    end else begin
      st_q         <= st_n;
      cnt_q        <= cnt_n;
      tc_q         <= tc_n;
      top_q        <= top_n;
      host_ack     <= ack_n;
      host_timeout <= to_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tim_q      <= '0;
      card_addr  <= '0;
      card_space <= '0;
      card_we    <= 1'b0;
      card_wdata <= '0;
    end else if (ld) begin
      tim_q      <= tim_in;
      card_addr  <= addr_in;
      card_space <= space_in;
      card_we    <= we_in;
      card_wdata <= wdata_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      host_rdata <= '0;
    end else if (rd_en) begin
      host_rdata <= rd_n;
    end
  end

  assign card_cmd = (st_q == SQ_STROBE) || (st_q == SQ_WDLY) || (st_q == SQ_WCHK);

endmodule

// File: rtl/card_win_seq.sv
module card_win_seq
  import card_win_pkg::*;
#(
  parameter int NWIN   = 3,
  parameter int OFS_W  = 20,
  parameter int PAGE_W = 6,
  parameter int DATA_W = 16,
  parameter int TO_CYC = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_we,
  input  logic [$clog2(NWIN*4)-1:0]  cfg_addr,
  input  logic [REG_W-1:0]           cfg_wdata,
  output logic [REG_W-1:0]           cfg_rdata,
  input  logic                       host_req,
  input  logic [$clog2(NWIN+1)-1:0]  host_win,
  input  logic [OFS_W-1:0]           host_ofs,
  input  logic                       host_wr,
  input  logic [DATA_W-1:0]          host_wdata,
  output logic                       host_ack,
  output logic [DATA_W-1:0]          host_rdata,
  output logic                       host_timeout,
  output logic [PAGE_W+OFS_W-1:0]    card_addr,
  output logic [1:0]                 card_space,
  output logic                       card_cmd,
  output logic                       card_we,
  output logic [DATA_W-1:0]          card_wdata,
  input  logic [DATA_W-1:0]          card_rdata,
  input  logic                       card_wait_n
);

  localparam int ADDR_W = $clog2(NWIN * 4);
  localparam int WSEL_W = $clog2(NWIN + 1);
  localparam int CA_W   = PAGE_W + OFS_W;

  logic [NWIN-1:0][REG_W-1:0] ctl_a;
  logic [NWIN-1:0][REG_W-1:0] ctl_b;
  logic                       win_ok;
  logic [CA_W-1:0]            xaddr;
  logic [1:0]                 xspace;
  win_tim_t                   xtim;

  card_win_regs #(
    .NWIN   (NWIN),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .ctl_a     (ctl_a),
    .ctl_b     (ctl_b)
  );

  card_win_xlate #(
    .NWIN   (NWIN),
    .WSEL_W (WSEL_W),
    .OFS_W  (OFS_W),
    .PAGE_W (PAGE_W)
  ) u_xlate (
    .ctl_a    (ctl_a),
    .ctl_b    (ctl_b),
    .host_win (host_win),
    .host_ofs (host_ofs),
    .win_ok   (win_ok),
    .xaddr    (xaddr),
    .xspace   (xspace),
    .xtim     (xtim)
  );

  card_win_strobe #(
    .CA_W   (CA_W),
    .DATA_W (DATA_W),
    .TO_CYC (TO_CYC)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (host_req),
    .win_ok       (win_ok),
    .tim_in       (xtim),
    .addr_in      (xaddr),
    .space_in     (xspace),
    .we_in        (host_wr),
    .wdata_in     (host_wdata),
    .card_rdata   (card_rdata),
    .card_wait_n  (card_wait_n),
    .card_addr    (card_addr),
    .card_space   (card_space),
    .card_we      (card_we),
    .card_wdata   (card_wdata),
    .card_cmd     (card_cmd),
    .host_ack     (host_ack),
    .host_timeout (host_timeout),
    .host_rdata   (host_rdata)
  );

endmodule

// File: rtl/card_win_chk.sv
module card_win_chk #(
  parameter int CA_W   = 26,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              card_cmd,
  input logic              host_ack,
  input logic              host_timeout,
  input logic [DATA_W-1:0] host_rdata,
  input logic [CA_W-1:0]   card_addr
);

  AST_TO_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    host_timeout |-> host_ack); // R6

  AST_TO_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    host_timeout |-> (host_rdata == {DATA_W{1'b1}})); // R6

  AST_ACK_NO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    host_ack |-> !card_cmd); // R4

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_cmd) |-> !host_ack); // R4

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (card_cmd && $past(card_cmd)) |-> $stable(card_addr)); // R11

endmodule

bind card_win_seq card_win_chk #(
  .CA_W   (CA_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .card_cmd     (card_cmd),
  .host_ack     (host_ack),
  .host_timeout (host_timeout),
  .host_rdata   (host_rdata),
  .card_addr    (card_addr)
);

// File: tb/sim_card_win_seq.sv
module sim_card_win_seq;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int TO_CYC = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        host_req = 1'b0;
  logic [1:0]  host_win = '0;
  logic [19:0] host_ofs = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic        host_ack;
  logic [15:0] host_rdata;
  logic        host_timeout;
  logic [25:0] card_addr;
  logic [1:0]  card_space;
  logic        card_cmd;
  logic        card_we;
  logic [15:0] card_wdata;
  logic [15:0] card_rdata = 16'h1000;
  logic        card_wait_n = 1'b1;

  always #2.5 clk = ~clk;

  card_win_seq u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .host_req     (host_req),
    .host_win     (host_win),
    .host_ofs     (host_ofs),
    .host_wr      (host_wr),
    .host_wdata   (host_wdata),
    .host_ack     (host_ack),
    .host_rdata   (host_rdata),
    .host_timeout (host_timeout),
    .card_addr    (card_addr),
    .card_space   (card_space),
    .card_cmd     (card_cmd),
    .card_we      (card_we),
    .card_wdata   (card_wdata),
    .card_rdata   (card_rdata),
    .card_wait_n  (card_wait_n)
  );

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  bit    mdl_on = 0;
  string stag = "R1";
  int    ack_cnt = 0;
  int    cmd_cyc = 0;
  int    to_cnt = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int          q[$];
  bit          need_smp, smp, to_f, mb, pc, adv;
  int          lowcnt, m_rec, it;
  logic        e_cmd, e_ack, e_to, e_we;
  logic [15:0] e_rd, e_wd, cap, c0, c1;
  logic [25:0] e_addr;
  logic [1:0]  e_space;
  logic [15:0] m_a [3];
  logic [15:0] m_b [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      need_smp = 0; smp = 0; to_f = 0; lowcnt = 0; m_rec = 0;
      e_cmd = 0; e_ack = 0; e_to = 0; e_we = 0;
      e_rd = '0; e_wd = '0; cap = '0; e_addr = '0; e_space = '0;
      for (int i = 0; i < 3; i++) begin m_a[i] = '0; m_b[i] = '0; end
    end else begin
      mb  = (q.size() != 0) || need_smp || smp;
      pc  = e_cmd;
      adv = 0;
      e_ack = 0;
      e_to  = 0;
      if (!mb) begin
        e_cmd = 0;
        if (host_req) begin
          if (host_win == 2'd3) begin
            e_ack = 1; e_rd = 16'hFFFF;
          end else begin
            c0 = m_a[host_win];
            c1 = m_b[host_win];
            e_addr = {c0[5:0], host_ofs};
            e_space = c0[7:6];
            e_we = host_wr;
            e_wd = host_wdata;
            m_rec = int'(c1[4:3]);
            to_f = 0;
            for (int i = 0; i <= int'(c0[9:8]); i++) q.push_back(0);
            for (int i = 0; i <= int'(c0[14:10]); i++) q.push_back(1);
            if (c1[0]) begin
              for (int i = 0; i <= int'(c1[2:1]); i++) q.push_back(1);
              need_smp = 1;
            end else begin
              for (int i = 0; i <= m_rec; i++) q.push_back(0);
              q.push_back(2);
            end
            adv = 1;
          end
        end
      end else if (smp) begin
        if (card_wait_n || lowcnt == TO_CYC - 1) begin
          smp = 0;
          to_f = !card_wait_n;
          for (int i = 0; i <= m_rec; i++) q.push_back(0);
          q.push_back(2);
          adv = 1;
        end else begin
          lowcnt++;
        end
      end else if (q.size() == 0) begin
        need_smp = 0; smp = 1; lowcnt = 0; e_cmd = 1;
      end else begin
        adv = 1;
      end
      if (adv) begin
        it = q.pop_front();
        if (it == 2) begin
          e_ack = 1; e_to = to_f; e_rd = cap; e_cmd = 0;
        end else begin
          e_cmd = (it == 1);
        end
      end
      if (pc && !e_cmd) cap = to_f ? 16'hFFFF : card_rdata;
      if (cfg_we && cfg_addr < 4'd12) begin
        if (cfg_addr[1]) m_b[cfg_addr[3:2]] = cfg_wdata & 16'h001F;
        else             m_a[cfg_addr[3:2]] = cfg_wdata & 16'h7FFF;
      end
    end
  end

  function automatic bit m_busy();
    return (q.size() != 0) || need_smp || smp;
  endfunction

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && mdl_on) begin
      chk(card_cmd === e_cmd, {"R4 R5 card_cmd in ", stag}, "card_cmd", card_cmd, e_cmd);
      chk(host_ack === e_ack, {"R4 host_ack in ", stag}, "host_ack", host_ack, e_ack);
      chk(host_timeout === e_to, {"R6 host_timeout in ", stag}, "host_timeout", host_timeout, e_to);
      if (e_ack)
        chk(host_rdata === e_rd, {"R7 host_rdata in ", stag}, "host_rdata", host_rdata, e_rd);
      if (e_cmd) begin
        chk(card_addr === e_addr, {"R3 R11 card_addr in ", stag}, "card_addr", card_addr, e_addr);
        chk(card_space === e_space, {"R3 R11 card_space in ", stag}, "card_space", card_space, e_space);
        chk(card_we === e_we, {"R3 R11 card_we in ", stag}, "card_we", card_we, e_we);
        chk(card_wdata === e_wd, {"R3 R11 card_wdata in ", stag}, "card_wdata", card_wdata, e_wd);
      end
      if (host_ack) ack_cnt++;
      if (card_cmd) cmd_cyc++;
      if (host_timeout) to_cnt++;
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, input logic [15:0] exp, input string tag);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata === exp, tag, "cfg_rdata", cfg_rdata, exp);
  endtask

  task automatic issue(input logic [1:0] w, input logic [19:0] o,
                       input bit wr, input logic [15:0] wd);
    @(negedge clk);
    host_req = 1; host_win = w; host_ofs = o; host_wr = wr; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    host_ofs = ~o; host_win = 2'd2; host_wr = ~wr; host_wdata = ~wd;
  endtask

  task automatic drain();
    int n = 0;
    while (m_busy() && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic clr_cnt();
    ack_cnt = 0; cmd_cyc = 0; to_cnt = 0;
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        card_rdata = card_rdata + 16'h1357;
      end
    join_none
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(card_cmd === 1'b0, "R1", "card_cmd", card_cmd, 0);
    chk(host_ack === 1'b0, "R1", "host_ack", host_ack, 0);
    chk(host_timeout === 1'b0, "R1", "host_timeout", host_timeout, 0);
    for (int a = 0; a < 12; a += 2) rd_reg(4'(a), 16'h0000, "R1");
    mdl_on = 1;

    // R2 register map
    stag = "R2";
    wr_reg(4'd4, 16'hFFFF);
    wr_reg(4'd6, 16'hFFFF);
    rd_reg(4'd4, 16'h7FFF, "R2");
    rd_reg(4'd5, 16'h7FFF, "R2");
    rd_reg(4'd6, 16'h001F, "R2");
    rd_reg(4'd7, 16'h001F, "R2");
    wr_reg(4'd12, 16'hFFFF);
    wr_reg(4'd14, 16'hFFFF);
    rd_reg(4'd12, 16'h0000, "R2");
    rd_reg(4'd14, 16'h0000, "R2");
    rd_reg(4'd0, 16'h0000, "R2");
    rd_reg(4'd10, 16'h0000, "R2");

    // Window setup
    wr_reg(4'd0, 16'h0E55);  // page 15, common, dly 2, len 3
    wr_reg(4'd2, 16'h0008);  // rec 1, no wait
    wr_reg(4'd4, 16'h00BF);  // page 3F, I/O, dly 0, len 0
    wr_reg(4'd6, 16'h0005);  // wdly 2, honour
    wr_reg(4'd8, 16'h7F00);  // page 0, attribute, dly 3, len 31
    wr_reg(4'd10, 16'h0018); // rec 3, no wait

    // R3 R4 R7 plain read
    stag = "R4"; clr_cnt();
    issue(2'd0, 20'hABCDE, 1'b0, 16'h0000);
    drain();
    chk(ack_cnt == 1, "R4", "ack count", ack_cnt, 1);
    chk(cmd_cyc == 4, "R4", "strobe cycles", cmd_cyc, 4);

    // R5 wait extension, write access
    stag = "R5"; clr_cnt();
    card_wait_n = 0;
    issue(2'd1, 20'h00123, 1'b1, 16'hBEEF);
    repeat (12) @(negedge clk);
    card_wait_n = 1;
    drain();
    chk(ack_cnt == 1, "R5", "ack count", ack_cnt, 1);
    chk(to_cnt == 0, "R5", "timeouts", to_cnt, 0);

    // R5 wait ignored when not honoured
    stag = "R5 ignore"; clr_cnt();
    card_wait_n = 0;
    issue(2'd2, 20'hFFFFF, 1'b0, 16'h0000);
    drain();
    card_wait_n = 1;
    chk(cmd_cyc == 32, "R5", "strobe cycles with wait ignored", cmd_cyc, 32);

    // R6 timeout
    stag = "R6"; clr_cnt();
    card_wait_n = 0;
    issue(2'd1, 20'h55555, 1'b0, 16'h0000);
    drain();
    card_wait_n = 1;
    chk(to_cnt == 1, "R6", "timeout pulses", to_cnt, 1);
    chk(cmd_cyc == 1 + 3 + TO_CYC, "R6", "strobe cycles", cmd_cyc, 1 + 3 + TO_CYC);

    // R8 invalid window
    stag = "R8"; clr_cnt();
    issue(2'd3, 20'h00001, 1'b0, 16'h0000);
    drain();
    chk(ack_cnt == 1, "R8", "ack count", ack_cnt, 1);
    chk(cmd_cyc == 0, "R8", "strobe cycles", cmd_cyc, 0);

    // R9 request held high across an access
    stag = "R9"; clr_cnt();
    @(negedge clk);
    host_req = 1; host_win = 2'd0; host_ofs = 20'h11111; host_wr = 0;
    repeat (11) @(negedge clk);
    host_req = 0;
    drain();
    chk(ack_cnt == 2, "R9", "ack count", ack_cnt, 2);
    chk(cmd_cyc == 8, "R9", "strobe cycles", cmd_cyc, 8);

    // R10 write on the accepting edge
    stag = "R10"; clr_cnt();
    @(negedge clk);
    host_req = 1; host_win = 2'd0; host_ofs = 20'h2468A; host_wr = 0;
    cfg_we = 1; cfg_addr = 4'd0; cfg_wdata = 16'h04EA;
    @(negedge clk);
    host_req = 0; cfg_we = 0;
    drain();
    chk(cmd_cyc == 4, "R10", "strobe cycles old timing", cmd_cyc, 4);
    clr_cnt();
    issue(2'd0, 20'h2468A, 1'b1, 16'h7777);
    drain();
    chk(cmd_cyc == 2, "R10", "strobe cycles new timing", cmd_cyc, 2);
    chk(ack_cnt == 1, "R10", "ack count", ack_cnt, 1);

    // R11 inputs changed during access are covered by issue()
    stag = "R11"; clr_cnt();
    issue(2'd2, 20'h0F0F0, 1'b1, 16'hA5A5);
    drain();
    chk(ack_cnt == 1, "R11", "ack count", ack_cnt, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule